// File: doc/BRIEF.md
# Flash program and erase sequencer

This block sits on the host side of a serial NOR flash. It turns a single request into the full command traffic the flash needs. The request is one of three operations: program a byte stream starting at an address, erase one sector, or erase the whole array. Before every program or erase command the block sends its own write-enable frame. It then reads the status byte once to confirm that the write-enable latch is set. After the command it opens a status-read frame and keeps clocking status bytes until the busy bit clears. A long program request is cut into chunks so that no program command runs past a 256-byte page boundary. Each chunk gets its own write-enable, command and busy wait.

The flash is reached through a byte-level SPI engine. The block raises `spi_sel` for the length of a frame and hands the engine one byte at a time with a valid/ready handshake. It waits for the byte returned on `spi_rx_valid` before it offers the next byte. Program data arrives on a valid/ready byte stream. `wr_ready` is high only in the cycle where the byte can be handed straight to the SPI engine, so the stream producer may stall at any time and sees back-pressure whenever the SPI engine stalls or the block is between data bytes. A request ends with a one-cycle `done` pulse. The two error flags are valid from that cycle and hold until the next request is accepted.

Top module: `flash_pe_seq`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle, and a request is taken on `cmd_valid && cmd_ready`. `cmd_op` encodes 0 = program, 1 = sector erase, 2 = bulk erase, 3 = no operation. A program of length 0, or operation 3, ends with `done` and sends no frame.
- R2: Every program or erase command frame is preceded by its own frame holding only the byte 06h. That frame is followed by a status frame of byte 05h and one read byte.
- R3: If bit 1 of that status byte is 0, the block sends no command, ends the request, and reports `err_wel`=1 with `err_timeout`=0.
- R4: A program request is split at every 256-byte boundary. Each chunk is min(bytes left, 256 - address mod 256) bytes long. Its frame is 02h, then three address bytes most significant first, then the data. Addresses wrap modulo 2^ADDR_W.
- R5: Data bytes are taken from the write stream in order, one per SPI byte. A stream byte is consumed only in a cycle where it is also handed to the SPI engine.
- R6: A sector erase frame is D8h followed by three address bytes. A bulk erase frame is the single byte C7h.
- R7: After each command frame a status frame (05h) stays open and status bytes are read until bit 0 is 0. No other frame starts before that.
- R8: If POLL_MAX status bytes in one poll frame all read busy, the request ends with `err_timeout`=1. A clear byte on the POLL_MAX-th read counts as success.
- R9: `done` is a one-cycle pulse. `err_wel` and `err_timeout` change only in the `done` cycle or in the cycle after a request is accepted.
- R10: `spi_sel` drops for at least one cycle between frames. `spi_tx_valid` is only high inside a frame. No byte is offered while the previous byte's reply is outstanding.
- R11: After reset the block is idle: `cmd_ready`=1, `spi_sel`=0, `done`=0, both error flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Block idle, request can be taken |
| cmd_op | input | 2 | Operation code (see R1) |
| cmd_addr | input | ADDR_W | Start address or sector address |
| cmd_len | input | ADDR_W+1 | Program length in bytes |
| wr_valid | input | 1 | Program byte valid |
| wr_ready | output | 1 | Program byte consumed |
| wr_data | input | 8 | Program byte |
| spi_sel | output | 1 | Frame active (chip select) |
| spi_tx_valid | output | 1 | Byte offered to SPI engine |
| spi_tx_ready | input | 1 | SPI engine takes the byte |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_rx_valid | input | 1 | Reply byte for the last byte sent |
| spi_rx_data | input | 8 | Reply byte |
| done | output | 1 | Request finished (one-cycle pulse) |
| err_wel | output | 1 | Write-enable latch was not set |
| err_timeout | output | 1 | Busy bit did not clear within the poll limit |

## Verification
The poll limit and the busy bit clearing can land on the same status byte. On the POLL_MAX-th read, the counter says stop and the flash says ready at once. The bench provokes this with a flash model that stays busy for exactly POLL_MAX-1 reads, and then for POLL_MAX reads. The first case must end cleanly and the second must report a timeout, with POLL_MAX status bytes read in both. A second coincidence is checked in the same sweep: the last byte of a program chunk that is also the last byte of the request, at offsets that end exactly on a page boundary.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_BERASE = 2'd2,
    OP_NONE   = 2'd3
  } fseq_op_e;

  localparam logic [7:0] FL_WEN    = 8'h06;
  localparam logic [7:0] FL_RDST   = 8'h05;
  localparam logic [7:0] FL_PROG   = 8'h02;
  localparam logic [7:0] FL_SERASE = 8'hD8;
  localparam logic [7:0] FL_BERASE = 8'hC7;

  localparam int FL_WEL_BIT  = 1;
  localparam int FL_BUSY_BIT = 0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WEN,
    ST_CHK_OP,
    ST_CHK_RD,
    ST_CMD_OP,
    ST_CMD_ADDR,
    ST_CMD_DATA,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_GAP,
    ST_FIN
  } fseq_st_e;

  function automatic logic [7:0] op_opcode(input fseq_op_e op);
    case (op)
      OP_PROG:   return FL_PROG;
      OP_SERASE: return FL_SERASE;
      default:   return FL_BERASE;
    endcase
  endfunction

endpackage

// File: rtl/fseq_chunker.sv
module fseq_chunker #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 18
) (
  input  logic [PAGE_W-1:0] addr_lo,
  input  logic [LEN_W-1:0]  left,
  output logic [PAGE_W:0]   chunk
);
  localparam int CHUNK_W = PAGE_W + 1;

  logic [CHUNK_W-1:0] span;

  always_comb begin
    span = CHUNK_W'(1 << PAGE_W) - CHUNK_W'(addr_lo);
    if (left < LEN_W'(span)) chunk = CHUNK_W'(left);
    else                     chunk = span;
  end
endmodule

// File: rtl/fseq_poll_cnt.sv
module fseq_poll_cnt #(
  parameter int POLL_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == CW'(POLL_MAX - 1));
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int PAGE_W   = 8,
  parameter int POLL_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W:0]   cmd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              spi_sel,
  output logic              spi_tx_valid,
  input  logic              spi_tx_ready,
  output logic [7:0]        spi_tx_data,
  input  logic              spi_rx_valid,
  input  logic [7:0]        spi_rx_data,
  output logic              done,
  output logic              err_wel,
  output logic              err_timeout
);
  localparam int LEN_W   = ADDR_W + 1;
  localparam int CHUNK_W = PAGE_W + 1;

  fseq_st_e             st_q, gap_nxt_q;
  fseq_op_e             op_q;
  logic                 waiting_q;
  logic [1:0]           abyte_q;
  logic [CHUNK_W-1:0]   chunk_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [LEN_W-1:0]     rem_q;
  logic                 pend_wel_q, pend_to_q;
  logic                 done_q, err_wel_q, err_to_q;

  logic                 tx_fire, rx_evt;
  logic [23:0]          addr24;
  logic [CHUNK_W-1:0]   chunk_w;
  logic                 poll_clr, poll_inc, poll_last;
  logic                 rx_busy, rx_wel;
  logic                 unused_rx;

  assign tx_fire   = spi_tx_valid && spi_tx_ready;
  assign rx_evt    = waiting_q && spi_rx_valid;
  assign addr24    = 24'(addr_q);
  assign rx_busy   = spi_rx_data[FL_BUSY_BIT];
  assign rx_wel    = spi_rx_data[FL_WEL_BIT];
  assign unused_rx = ^spi_rx_data[7:2];

  fseq_chunker #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chunk (
    .addr_lo (addr_q[PAGE_W-1:0]),
    .left    (rem_q),
    .chunk   (chunk_w)
  );

  assign poll_clr = (st_q == ST_POLL_OP);
  assign poll_inc = (st_q == ST_POLL_RD) && rx_evt && rx_busy;

  fseq_poll_cnt #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .last  (poll_last)
  );

  // Frame and byte drive
  always_comb begin
    spi_sel     = 1'b1;
    spi_tx_data = 8'h00;
    case (st_q)
      ST_IDLE, ST_GAP, ST_FIN: spi_sel = 1'b0;
      default: ;
    endcase
    case (st_q)
      ST_WEN:                 spi_tx_data = FL_WEN;
      ST_CHK_OP, ST_POLL_OP:  spi_tx_data = FL_RDST;
      ST_CMD_OP:              spi_tx_data = op_opcode(op_q);
      ST_CMD_ADDR: begin
        case (abyte_q)
          2'd0:    spi_tx_data = addr24[23:16];
          2'd1:    spi_tx_data = addr24[15:8];
          default: spi_tx_data = addr24[7:0];
        endcase
      end
      ST_CMD_DATA:            spi_tx_data = wr_data;
      default:                spi_tx_data = 8'h00;
    endcase
    spi_tx_valid = spi_sel && !waiting_q && ((st_q != ST_CMD_DATA) || wr_valid);
    wr_ready     = (st_q == ST_CMD_DATA) && !waiting_q && spi_tx_ready;
  end

  assign cmd_ready   = (st_q == ST_IDLE);
  assign done        = done_q;
  assign err_wel     = err_wel_q;
  assign err_timeout = err_to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      gap_nxt_q  <= ST_IDLE;
      op_q       <= OP_NONE;
      waiting_q  <= 1'b0;
      abyte_q    <= '0;
      chunk_q    <= '0;
      addr_q     <= '0;
      rem_q      <= '0;
      pend_wel_q <= 1'b0;
      pend_to_q  <= 1'b0;
      done_q     <= 1'b0;
      err_wel_q  <= 1'b0;
      err_to_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tx_fire)     waiting_q <= 1'b1;
      else if (rx_evt) waiting_q <= 1'b0;

      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q       <= fseq_op_e'(cmd_op);
            addr_q     <= cmd_addr;
            rem_q      <= cmd_len;
            pend_wel_q <= 1'b0;
            pend_to_q  <= 1'b0;
            err_wel_q  <= 1'b0;
            err_to_q   <= 1'b0;
            if ((cmd_op == OP_NONE) || ((cmd_op == OP_PROG) && (cmd_len == '0)))
              st_q <= ST_FIN;
            else
              st_q <= ST_WEN;
          end
        end
        ST_WEN: begin
          if (rx_evt) begin
            st_q      <= ST_GAP;
            gap_nxt_q <= ST_CHK_OP;
          end
        end
        ST_CHK_OP: begin
          if (rx_evt) st_q <= ST_CHK_RD;
        end
        ST_CHK_RD: begin
          if (rx_evt) begin
            st_q <= ST_GAP;
            if (rx_wel) begin
              gap_nxt_q <= ST_CMD_OP;
            end else begin
              pend_wel_q <= 1'b1;
              gap_nxt_q  <= ST_FIN;
            end
          end
        end
        ST_CMD_OP: begin
          if (rx_evt) begin
            abyte_q <= '0;
            if (op_q == OP_BERASE) begin
              st_q      <= ST_GAP;
              gap_nxt_q <= ST_POLL_OP;
            end else begin
              st_q <= ST_CMD_ADDR;
            end
          end
        end
        ST_CMD_ADDR: begin
          if (rx_evt) begin
            abyte_q <= abyte_q + 2'd1;
            if (abyte_q == 2'd2) begin
              if (op_q == OP_PROG) begin
                st_q    <= ST_CMD_DATA;
                chunk_q <= chunk_w;
              end else begin
                st_q      <= ST_GAP;
                gap_nxt_q <= ST_POLL_OP;
              end
            end
          end
        end
        ST_CMD_DATA: begin
          if (tx_fire) begin
            chunk_q <= chunk_q - CHUNK_W'(1);
            addr_q  <= addr_q + ADDR_W'(1);
            rem_q   <= rem_q - LEN_W'(1);
          end
          if (rx_evt && (chunk_q == '0)) begin
            st_q      <= ST_GAP;
            gap_nxt_q <= ST_POLL_OP;
          end
        end
        ST_POLL_OP: begin
          if (rx_evt) st_q <= ST_POLL_RD;
        end
        ST_POLL_RD: begin
          if (rx_evt) begin
            if (!rx_busy) begin
              st_q <= ST_GAP;
              if ((op_q == OP_PROG) && (rem_q != '0)) gap_nxt_q <= ST_WEN;
              else                                    gap_nxt_q <= ST_FIN;
            end else if (poll_last) begin
              pend_to_q <= 1'b1;
              st_q      <= ST_GAP;
              gap_nxt_q <= ST_FIN;
            end
          end
        end
        ST_GAP: st_q <= gap_nxt_q;
        ST_FIN: begin
          done_q    <= 1'b1;
          err_wel_q <= pend_wel_q;
          err_to_q  <= pend_to_q;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic       spi_sel,
  input logic       spi_tx_valid,
  input logic       spi_tx_ready,
  input logic [7:0] spi_tx_data,
  input logic       spi_rx_valid,
  input logic       done,
  input logic       err_wel,
  input logic       err_timeout
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            out_q <= 1'b0;
    else if (spi_tx_valid && spi_tx_ready) out_q <= 1'b1;
    else if (spi_rx_valid)                 out_q <= 1'b0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!spi_sel && !spi_tx_valid));

  assert_wr_with_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (spi_tx_valid && spi_tx_ready && (spi_tx_data == wr_data)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(cmd_valid && cmd_ready)) |-> ($stable(err_wel) && $stable(err_timeout)));

  assert_err_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_wel && err_timeout));

  assert_tx_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> spi_sel);

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !spi_tx_valid);

  assert_close_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_sel |-> !out_q);
endmodule

bind flash_pe_seq flash_pe_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_data      (wr_data),
  .spi_sel      (spi_sel),
  .spi_tx_valid (spi_tx_valid),
  .spi_tx_ready (spi_tx_ready),
  .spi_tx_data  (spi_tx_data),
  .spi_rx_valid (spi_rx_valid),
  .done         (done),
  .err_wel      (err_wel),
  .err_timeout  (err_timeout)
);

// File: tb/flash_pe_seq_tb.sv
`timescale 1ns/1ps
module flash_pe_seq_tb;
  localparam int ADDR_W = 17;
  localparam int POLL   = 16;
  localparam int ASIZE  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_op = 2'd0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [ADDR_W:0]   cmd_len = '0;
  logic              wr_valid;
  logic              wr_ready;
  logic [7:0]        wr_data;
  logic              spi_sel, spi_tx_valid, spi_tx_ready;
  logic [7:0]        spi_tx_data, spi_rx_data;
  logic              spi_rx_valid;
  logic              done, err_wel, err_timeout;

  always #10 clk = ~clk;

  flash_pe_seq #(.ADDR_W(ADDR_W), .PAGE_W(8), .POLL_MAX(POLL)) u_dut (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // flash model state
  int bidx, busy_left, busy_n, viol, dpos, data_err;
  int wren_cnt, pp_cnt, se_cnt, be_cnt, frame_cnt, last_rd, cur_a, er_addr, er_len;
  int pp_addr[8], pp_len[8];
  logic [7:0] fop;
  bit wel, wel_block, stall;
  logic sel_d, ph;
  logic [7:0] seed;
  int wk;

  function automatic logic [7:0] pat(input int k, input logic [7:0] s);
    return 8'(k * 7) ^ s;
  endfunction

  always_comb wr_data = pat(wk, seed);

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      spi_rx_valid <= 1'b0; spi_rx_data <= 8'h00; spi_tx_ready <= 1'b1;
      sel_d <= 1'b0; ph <= 1'b0; wr_valid <= 1'b0;
      bidx = 0; wel = 0; busy_left = 0;
    end else begin
      ph <= ~ph;
      spi_rx_valid <= 1'b0;
      spi_tx_ready <= stall ? ~spi_tx_ready : 1'b1;
      if (wr_valid && wr_ready) wk <= wk + 1;
      if (!wr_valid || wr_ready) wr_valid <= stall ? ph : 1'b1;
      if (spi_tx_valid && !spi_sel) viol++;
      if (spi_tx_valid && spi_tx_ready) begin
        if (spi_rx_valid) viol++;
        spi_rx_valid <= 1'b1;
        spi_rx_data  <= 8'h00;
        if (bidx == 0) begin
          fop = spi_tx_data; frame_cnt++; cur_a = 0;
          if (fop != 8'h05 && busy_left > 0) viol++;
        end else if (fop == 8'h05) begin
          spi_rx_data <= {6'b0, wel, (busy_left > 0)};
          if (busy_left > 0) busy_left--;
        end else if (bidx <= 3) begin
          cur_a = (cur_a << 8) | int'(spi_tx_data);
        end else if (fop == 8'h02) begin
          if (spi_tx_data != pat(dpos, seed)) data_err++;
          dpos++;
        end
        bidx++;
      end
      sel_d <= spi_sel;
      if (sel_d && !spi_sel) begin
        case (fop)
          8'h06: begin wren_cnt++; if (!wel_block) wel = 1; end
          8'h05: last_rd = bidx - 1;
          8'h02: begin
            if (!wel) viol++;
            if (pp_cnt < 8) begin pp_addr[pp_cnt] = cur_a; pp_len[pp_cnt] = bidx - 4; end
            pp_cnt++; wel = 0; busy_left = busy_n;
          end
          8'hD8: begin if (!wel) viol++; se_cnt++; er_addr = cur_a; er_len = bidx; wel = 0; busy_left = busy_n; end
          8'hC7: begin if (!wel) viol++; be_cnt++; er_len = bidx; wel = 0; busy_left = busy_n; end
          default: viol++;
        endcase
        bidx = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr_model(input int bn, input bit wb, input bit st, input logic [7:0] sd);
    busy_n = bn; wel_block = wb; stall = st; seed = sd;
    wk = 0; dpos = 0; data_err = 0; wren_cnt = 0; pp_cnt = 0; se_cnt = 0; be_cnt = 0;
    frame_cnt = 0; last_rd = 0; er_addr = -1; er_len = 0; busy_left = 0; wel = 0;
  endtask

  bit g_done, g_wel, g_to;

  task automatic do_op(input logic [1:0] op, input int a, input int len);
    int t;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(a); cmd_len = (ADDR_W+1)'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1", "cmd_ready low after accept", int'(cmd_ready), 0);
    t = 0;
    while (!done && t < 30000) begin @(negedge clk); t++; end
    g_done = done; g_wel = err_wel; g_to = err_timeout;
    chk("R9", "done seen", int'(g_done), 1);
    @(negedge clk);
    chk("R9", "done is one cycle", int'(done), 0);
  endtask

  task automatic prog_run(input int a, input int len, input bit st, input int bn);
    int ea, r, n, bad, c;
    clr_model(bn, 0, st, 8'(a + len));
    do_op(2'd0, a, len);
    ea = a; r = len; n = 0; bad = 0;
    while (r > 0) begin
      c = 256 - (ea % 256);
      if (r < c) c = r;
      if (n < 8 && (pp_addr[n] != ea || pp_len[n] != c)) bad++;
      n++; ea = (ea + c) % ASIZE; r -= c;
    end
    chk("R4", $sformatf("chunk count a=%0d len=%0d", a, len), pp_cnt, n);
    chk("R4", "chunk address/length mismatches", bad, 0);
    chk("R5", "data byte mismatches", data_err, 0);
    chk("R5", "data bytes taken", dpos, len);
    chk("R2", "write-enable frames", wren_cnt, n);
    chk("R7", "protocol violations", viol, 0);
    chk("R9", "error flags clear", int'(g_wel) + int'(g_to), 0);
  endtask

  always @(negedge clk) begin
    if (cyc >= 190000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int offs[5] = '{0, 1, 100, 254, 255};
    int lens[6] = '{1, 2, 255, 256, 257, 520};
    clr_model(0, 0, 0, 8'h00);
    viol = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "cmd_ready in reset", int'(cmd_ready), 1);
    chk("R11", "spi_sel in reset", int'(spi_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "idle after reset", int'(cmd_ready) + 2 * int'(spi_sel) + 4 * int'(done), 1);
    chk("R11", "error flags after reset", int'(err_wel) + int'(err_timeout), 0);

    // R4/R5 sweep over offsets and lengths, alternate stalls
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 6; j++)
        prog_run(offs[i], lens[j], 1'((i + j) % 2), (i + j) % 4);
    // R4 wrap at the top of the array
    prog_run(ASIZE - 128, 300, 1'b1, 2);

    // R6 sector erase
    clr_model(5, 0, 0, 8'h00);
    do_op(2'd1, 'h08123, 0);
    chk("R6", "sector erase frames", se_cnt, 1);
    chk("R6", "sector erase address", er_addr, 'h08123);
    chk("R6", "sector erase frame bytes", er_len, 4);
    chk("R2", "write-enable before sector erase", wren_cnt, 1);
    chk("R7", "status bytes read after erase", last_rd, 6);

    // R6 bulk erase
    clr_model(7, 0, 1, 8'h00);
    do_op(2'd2, 'h1234, 0);
    chk("R6", "bulk erase frames", be_cnt, 1);
    chk("R6", "bulk erase frame bytes", er_len, 1);
    chk("R7", "protocol violations", viol, 0);

    // R3 write-enable latch not set
    clr_model(0, 1, 0, 8'h00);
    do_op(2'd0, 'h40, 10);
    chk("R3", "err_wel", int'(g_wel), 1);
    chk("R3", "err_timeout", int'(g_to), 0);
    chk("R3", "program frames", pp_cnt, 0);
    chk("R3", "frames sent", frame_cnt, 2);
    repeat (5) @(negedge clk);
    chk("R9", "err_wel held while idle", int'(err_wel), 1);

    // R8 busy clears on the last allowed read
    clr_model(POLL - 1, 0, 0, 8'h00);
    do_op(2'd1, 'h10000, 0);
    chk("R9", "err_wel cleared by next request", int'(g_wel), 0);
    chk("R8", "no timeout at limit", int'(g_to), 0);
    chk("R8", "status reads at limit", last_rd, POLL);

    // R8 busy one read longer
    clr_model(POLL, 0, 0, 8'h00);
    do_op(2'd1, 'h18000, 0);
    chk("R8", "timeout raised", int'(g_to), 1);
    chk("R8", "status reads before timeout", last_rd, POLL);
    chk("R8", "err_wel with timeout", int'(g_wel), 0);

    // R1 empty requests
    clr_model(0, 0, 0, 8'h00);
    do_op(2'd0, 'h10, 0);
    chk("R1", "frames for zero-length program", frame_cnt, 0);
    chk("R9", "timeout cleared by next request", int'(g_to), 0);
    do_op(2'd3, 'h10, 5);
    chk("R1", "frames for no-operation", frame_cnt, 0);
    chk("R1", "no error on no-operation", int'(g_wel) + int'(g_to), 0);
    chk("R10", "protocol violations overall", viol, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule